// File: doc/BRIEF.md
# NAND bus cycle generator

This block is the host-side engine for an 8-bit multiplexed NAND flash bus. A controller hands it one request at a time: a command byte, an address byte, a data byte to write, a data byte to read, or a wait for the flash to become ready. The engine turns each request into chip-enable, command-latch, address-latch, write-strobe and read-strobe waveforms. It drives the shared I/O byte through an output enable and captures read bytes. Every strobe width and every gap between bus cycles is counted in system clock cycles.

All timing minimums are parameters in nanoseconds. Each one becomes a clock count that is rounded up from the clock period, and the state machine never holds a phase longer than that count requires. Command sequencing, ECC and bad-block handling are left to the controller above.

The state machine has eight states:
- `ST_IDLE` waits for a request.
- `ST_GAP` holds until the inter-cycle gap for the accepted operation has elapsed.
- `ST_WLOW` and `ST_WHIGH` form a write-type cycle.
- `ST_RLOW` and `ST_RHIGH` form a read cycle.
- `ST_POLL` watches the synchronized ready/busy line.
- `ST_SETTLE` enforces the ready-to-read delay.

Transitions:
- IDLE→GAP on an accepted request.
- GAP→WLOW for command, address or write.
- GAP→RLOW for read.
- GAP→POLL for wait.
- GAP→IDLE for the unused codes.
- WLOW→WHIGH→IDLE, RLOW→RHIGH→IDLE and POLL→SETTLE→IDLE, each phase ending when its counter expires.

Top module: `nand_cycle_gen`

## Requirements
- R1: Op code 0 (command) produces one write-type cycle. CLE is high, ALE is low, the output enable is on and the request byte is on the I/O bus while the write strobe is low. The byte is latched at the write strobe's rising edge.
- R2: Op code 1 (address) produces one write-type cycle with ALE high, CLE low, the output enable on and the request byte on the bus while the write strobe is low.
- R3: Op code 2 (data write) produces one write-type cycle with both latch enables low and the byte driven. In every write-type cycle the write strobe stays low for at least 2 cycles and high for at least 2 cycles before it falls again. These counts come from 12 ns low, 10 ns high and a 25 ns cycle at 8 ns per clock.
- R4: A data write that follows an address cycle has its write-strobe rising edge at least 9 cycles (70 ns) after the rising edge of that address cycle.
- R5: Op code 3 (read) holds the read strobe low for 3 cycles, the larger of the 12 ns width and the 20 ns access time. The output enable is off whenever the read strobe is low. The byte present on the bus as the read strobe rises is returned on rsp_data with rsp_done.
- R6: The read strobe falls at least 8 cycles (60 ns) after the last write-strobe rising edge.
- R7: The write strobe falls at least 13 cycles (100 ns) after the last read-strobe rising edge.
- R8: Op code 4 (wait) does not start sampling ready until 13 cycles (100 ns) after the last write-strobe rise. It samples rb_n (low = busy) through a two-stage synchronizer and then waits 3 more cycles (20 ns) before reporting done. Done therefore comes at least 16 cycles after that write-strobe rise and at least 5 cycles after rb_n rises.
- R9: req_ready is high only in IDLE, and each accepted request yields exactly one single-cycle rsp_done. Out of reset the chip enable, write strobe and read strobe are high, the output enable and rsp_done are low, and req_ready is high.
- R10: Each nanosecond minimum becomes ceil(ns / CLK_NS) cycles, and back-to-back requests wait no longer than that. An address cycle followed directly by a data write gives exactly 9 cycles between write-strobe rising edges. A command followed directly by a read gives exactly 8 cycles from the write-strobe rise to the read-strobe fall.
- R11: CLE and ALE are never high together, and the write and read strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request accepted on this edge |
| req_op | input | 3 | 0 command, 1 address, 2 write, 3 read, 4 wait; 5–7 finish with no bus activity |
| req_byte | input | 8 | Command, address or write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Byte captured by the last read |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Byte driven onto the I/O bus |
| nand_io_oe | output | 1 | Output enable for nand_io_out |
| nand_io_in | input | 8 | Byte read from the I/O bus |
| nand_rb_n | input | 1 | Ready/busy from the flash, low = busy |

## Verification
A free-running cycle index is sampled on the falling clock edge. Each strobe edge is stamped with that index, so every width and gap is checked as a difference of indices at the cycle the edge becomes visible, not at a guessed delay. For back-to-back requests the address-to-data gap must be exactly 9 cycles and the command-to-read gap exactly 8. A request is issued in the same cycle the previous done is seen, so these exact values follow from the state sequence GAP, strobe low, strobe high, IDLE.

Read bytes are compared on the done cycle against the pattern the bench placed on the bus when the read strobe fell. A wait's done cycle is compared with the latest write-strobe rise (at least 16 cycles later) and with the cycle the modelled busy period ended (at least 5 cycles later).

// File: rtl/nand_cyc_pkg.sv
package nand_cyc_pkg;

    typedef enum logic [2:0] {
        OP_CMD   = 3'd0,
        OP_ADDR  = 3'd1,
        OP_WRITE = 3'd2,
        OP_READ  = 3'd3,
        OP_WAIT  = 3'd4
    } bus_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_WLOW,
        ST_WHIGH,
        ST_RLOW,
        ST_RHIGH,
        ST_POLL,
        ST_SETTLE
    } cyc_state_e;

    // nanoseconds to clock cycles, rounded up
    function automatic int ns2cyc(int ns, int per);
        return (ns + per - 1) / per;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nand_sync2.sv
module nand_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            dout   <= RST_VAL;
        end else begin
            meta_q <= din;
            dout   <= meta_q;
        end
    end
endmodule

// File: rtl/nand_age_ctr.sv
// Counts clock periods since the last clear; saturates at its maximum.
module nand_age_ctr #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    output logic [W-1:0] age
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            age <= '1;
        else if (clear)
            age <= '0;
        else if (age != '1)
            age <= age + 1'b1;
    end
endmodule

// File: rtl/nand_cycle_gen.sv
module nand_cycle_gen
    import nand_cyc_pkg::*;
#(
    parameter int CLK_NS    = 8,
    parameter int T_WP_NS   = 12,
    parameter int T_WH_NS   = 10,
    parameter int T_WC_NS   = 25,
    parameter int T_RP_NS   = 12,
    parameter int T_REH_NS  = 10,
    parameter int T_RC_NS   = 25,
    parameter int T_REA_NS  = 20,
    parameter int T_ADL_NS  = 70,
    parameter int T_WHR_NS  = 60,
    parameter int T_RHW_NS  = 100,
    parameter int T_WB_NS   = 100,
    parameter int T_RR_NS   = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic [2:0] req_op,
    input  logic [7:0] req_byte,
    output logic       rsp_done,
    output logic [7:0] rsp_data,
    output logic       nand_ce_n,
    output logic       nand_cle,
    output logic       nand_ale,
    output logic       nand_we_n,
    output logic       nand_re_n,
    output logic [7:0] nand_io_out,
    output logic       nand_io_oe,
    input  logic [7:0] nand_io_in,
    input  logic       nand_rb_n
);
    localparam int WP_C   = imax(ns2cyc(T_WP_NS, CLK_NS), 1);
    localparam int WH_C   = imax(imax(ns2cyc(T_WH_NS, CLK_NS), ns2cyc(T_WC_NS, CLK_NS) - WP_C), 1);
    localparam int RP_C   = imax(imax(ns2cyc(T_RP_NS, CLK_NS), ns2cyc(T_REA_NS, CLK_NS)), 1);
    localparam int REH_C  = imax(imax(ns2cyc(T_REH_NS, CLK_NS), ns2cyc(T_RC_NS, CLK_NS) - RP_C), 1);
    localparam int ADL_C  = ns2cyc(T_ADL_NS, CLK_NS);
    localparam int WHR_C  = ns2cyc(T_WHR_NS, CLK_NS);
    localparam int RHW_C  = ns2cyc(T_RHW_NS, CLK_NS);
    localparam int WB_C   = ns2cyc(T_WB_NS, CLK_NS);
    localparam int RR_C   = imax(ns2cyc(T_RR_NS, CLK_NS), 1);
    localparam int AGE_MAX = imax(imax(ADL_C, WHR_C), imax(RHW_C, WB_C)) + 1;
    localparam int AGE_W  = $clog2(AGE_MAX + 1);
    localparam int PH_MAX = imax(imax(WP_C, WH_C), imax(imax(RP_C, REH_C), RR_C));
    localparam int PH_W   = $clog2(PH_MAX + 1);

    cyc_state_e        state_q, state_d;
    logic [PH_W-1:0]   ph_q, ph_d;
    bus_op_e           op_q;
    logic [7:0]        byte_q;
    logic              after_addr_q;
    logic              gap_ok;
    logic              rb_s;
    logic [AGE_W-1:0]  we_age, re_age;
    logic              we_rise_now, re_rise_now;
    int                we_age_i, re_age_i;

    assign we_rise_now = (state_q == ST_WLOW) && (ph_q == '0);
    assign re_rise_now = (state_q == ST_RLOW) && (ph_q == '0);

    nand_sync2 #(.RST_VAL(1'b0)) u_rb_sync (
        .clk(clk), .rst_n(rst_n), .din(nand_rb_n), .dout(rb_s)
    );

    nand_age_ctr #(.W(AGE_W)) u_we_age (
        .clk(clk), .rst_n(rst_n), .clear(we_rise_now), .age(we_age)
    );

    nand_age_ctr #(.W(AGE_W)) u_re_age (
        .clk(clk), .rst_n(rst_n), .clear(re_rise_now), .age(re_age)
    );

    // gap condition: a strobe edge leaving ST_GAP lands one period after this cycle
    always_comb begin
        we_age_i = int'(we_age);
        re_age_i = int'(re_age);
        unique case (op_q)
            OP_CMD, OP_ADDR: gap_ok = (re_age_i + 1 >= RHW_C);
            OP_WRITE:        gap_ok = (re_age_i + 1 >= RHW_C) &&
                                      (!after_addr_q || (we_age_i + 1 + WP_C >= ADL_C));
            OP_READ:         gap_ok = (we_age_i + 1 >= WHR_C);
            OP_WAIT:         gap_ok = (we_age_i + 1 >= WB_C);
            default:         gap_ok = 1'b1;
        endcase
    end

    // next state and phase counter
    always_comb begin
        state_d = state_q;
        ph_d    = (ph_q != '0) ? ph_q - 1'b1 : '0;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_GAP;
            ST_GAP: begin
                if (gap_ok) begin
                    unique case (op_q)
                        OP_CMD, OP_ADDR, OP_WRITE: begin
                            state_d = ST_WLOW;
                            ph_d    = PH_W'(WP_C - 1);
                        end
                        OP_READ: begin
                            state_d = ST_RLOW;
                            ph_d    = PH_W'(RP_C - 1);
                        end
                        OP_WAIT: state_d = ST_POLL;
                        default: state_d = ST_IDLE;
                    endcase
                end
            end
            ST_WLOW: if (ph_q == '0) begin
                state_d = ST_WHIGH;
                ph_d    = PH_W'(WH_C - 1);
            end
            ST_WHIGH: if (ph_q == '0) state_d = ST_IDLE;
            ST_RLOW: if (ph_q == '0) begin
                state_d = ST_RHIGH;
                ph_d    = PH_W'(REH_C - 1);
            end
            ST_RHIGH: if (ph_q == '0) state_d = ST_IDLE;
            ST_POLL: if (rb_s) begin
                state_d = ST_SETTLE;
                ph_d    = PH_W'(RR_C - 1);
            end
            ST_SETTLE: if (ph_q == '0) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and request/response holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            ph_q         <= '0;
            op_q         <= OP_CMD;
            byte_q       <= '0;
            after_addr_q <= 1'b0;
            rsp_data     <= '0;
            rsp_done     <= 1'b0;
        end else begin
            state_q  <= state_d;
            ph_q     <= ph_d;
            rsp_done <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
            if (state_q == ST_IDLE && req_valid) begin
                op_q   <= bus_op_e'(req_op);
                byte_q <= req_byte;
            end
            if (state_q == ST_WHIGH && ph_q == '0)
                after_addr_q <= (op_q == OP_ADDR);
            if (re_rise_now)
                rsp_data <= nand_io_in;
        end
    end

    // outputs decoded from the state
    always_comb begin
        logic wr_phase;
        wr_phase    = (state_q == ST_GAP) || (state_q == ST_WLOW) || (state_q == ST_WHIGH);
        req_ready   = (state_q == ST_IDLE);
        nand_ce_n   = (state_q == ST_IDLE);
        nand_we_n   = (state_q != ST_WLOW);
        nand_re_n   = (state_q != ST_RLOW);
        nand_cle    = wr_phase && (op_q == OP_CMD);
        nand_ale    = wr_phase && (op_q == OP_ADDR);
        nand_io_oe  = ((state_q == ST_WLOW) || (state_q == ST_WHIGH)) &&
                      ((op_q == OP_CMD) || (op_q == OP_ADDR) || (op_q == OP_WRITE));
        nand_io_out = byte_q;
    end

endmodule

// File: rtl/nand_cyc_chk.sv
module nand_cyc_chk
    import nand_cyc_pkg::*;
#(
    parameter int CLK_NS   = 8,
    parameter int T_WP_NS  = 12,
    parameter int T_RP_NS  = 12,
    parameter int T_REA_NS = 20,
    parameter int T_WHR_NS = 60
) (
    input logic clk,
    input logic rst_n,
    input logic cle,
    input logic ale,
    input logic we_n,
    input logic re_n,
    input logic io_oe,
    input logic rsp_done,
    input logic req_ready
);
    localparam int WP_C  = imax(ns2cyc(T_WP_NS, CLK_NS), 1);
    localparam int RP_C  = imax(imax(ns2cyc(T_RP_NS, CLK_NS), ns2cyc(T_REA_NS, CLK_NS)), 1);
    localparam int WHR_C = ns2cyc(T_WHR_NS, CLK_NS);

    logic [7:0] we_low_cnt, re_low_cnt, since_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
            re_low_cnt <= '0;
            since_we   <= '1;
        end else begin
            we_low_cnt <= !we_n ? ((we_low_cnt != '1) ? we_low_cnt + 1'b1 : we_low_cnt) : '0;
            re_low_cnt <= !re_n ? ((re_low_cnt != '1) ? re_low_cnt + 1'b1 : re_low_cnt) : '0;
            since_we   <= !we_n ? '0 : ((since_we != '1) ? since_we + 1'b1 : since_we);
        end
    end

    p_latch_excl_r11: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !re_n));
    p_oe_off_read_r5: assert property (@(posedge clk) disable iff (!rst_n) !re_n |-> !io_oe);
    p_we_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (int'(we_low_cnt) >= WP_C));
    p_re_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(re_n) |-> (int'(re_low_cnt) >= RP_C));
    p_whr_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(re_n) |-> (int'(since_we) >= WHR_C));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n) rsp_done |=> !rsp_done);
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n) rsp_done |-> req_ready);

endmodule

bind nand_cycle_gen nand_cyc_chk #(
    .CLK_NS(CLK_NS), .T_WP_NS(T_WP_NS), .T_RP_NS(T_RP_NS),
    .T_REA_NS(T_REA_NS), .T_WHR_NS(T_WHR_NS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cle(nand_cle), .ale(nand_ale),
    .we_n(nand_we_n), .re_n(nand_re_n), .io_oe(nand_io_oe),
    .rsp_done(rsp_done), .req_ready(req_ready)
);

// File: tb/tb_nand_cycle_gen.sv
module tb_nand_cycle_gen;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = 3'd0;
    logic [7:0] req_byte = 8'd0;
    logic       req_ready, rsp_done;
    logic [7:0] rsp_data;
    logic       ce_n, cle, ale, we_n, re_n, io_oe;
    logic [7:0] io_out;
    logic [7:0] io_in = 8'd0;
    logic       rb_n = 1'b1;

    nand_cycle_gen dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_byte(req_byte), .rsp_done(rsp_done), .rsp_data(rsp_data),
        .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n),
        .nand_re_n(re_n), .nand_io_out(io_out), .nand_io_oe(io_oe),
        .nand_io_in(io_in), .nand_rb_n(rb_n)
    );

    // expected cycle counts at 8 ns (ceil of the ns minimums)
    localparam int E_WP = 2, E_WH = 2, E_RP = 3, E_ADL = 9, E_WHR = 8;
    localparam int E_RHW = 13, E_WB = 13, E_RR = 3, E_SYNC = 2;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_cmp = 0, n_bad = 0;

    task automatic check(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rd_pat(int idx);
        return 8'((idx * 29 + 91) ^ (idx >> 3));
    endfunction

    // monitor and flash model state
    int cur_op = 0;
    logic [7:0] cur_byte = 8'd0;
    bit exact_adl = 0, exact_whr = 0;
    bit prev_we = 1, prev_re = 1, after_addr = 0;
    logic samp_cle = 0, samp_ale = 0, samp_oe = 0;
    logic [7:0] samp_io = 8'd0;
    int we_fall = 0, we_rise = -1000, re_fall = 0, re_rise = -1000, addr_rise = -1000;
    int rd_idx = 0, busy_dly = 0, busy_left = 0, rb_rise = -1000;

    always @(negedge clk) begin
        if (rst_n) begin
            check(!(cle && ale), "R11 cle/ale overlap", int'(cle & ale), 0);
            check(!(!we_n && !re_n), "R11 strobe overlap", int'(!we_n && !re_n), 0);
            if (!prev_we && we_n) begin
                check(cyc - we_fall >= E_WP, "R3 we low width", cyc - we_fall, E_WP);
                check(samp_oe && samp_io == cur_byte,
                      (cur_op == 0) ? "R1 cmd byte" : (cur_op == 1) ? "R2 addr byte" : "R3 data byte",
                      int'(samp_io), int'(cur_byte));
                check(samp_cle == (cur_op == 0), "R1 cle level", int'(samp_cle), int'(cur_op == 0));
                check(samp_ale == (cur_op == 1), "R2 ale level", int'(samp_ale), int'(cur_op == 1));
                if (cur_op == 2 && after_addr) begin
                    check(cyc - addr_rise >= E_ADL, "R4 addr to data", cyc - addr_rise, E_ADL);
                    if (exact_adl)
                        check(cyc - addr_rise == E_ADL, "R10 adl exact", cyc - addr_rise, E_ADL);
                end
                after_addr = (cur_op == 1);
                if (cur_op == 1) addr_rise = cyc;
                we_rise = cyc;
                if (cur_op == 0 && (cur_byte == 8'h10 || cur_byte == 8'h30 || cur_byte == 8'hD0)) begin
                    busy_dly  = 3;
                    busy_left = 4 + int'($urandom_range(36, 0));
                end
            end
            if (prev_we && !we_n) begin
                check(cyc - we_rise >= E_WH, "R3 we high width", cyc - we_rise, E_WH);
                check(cyc - re_rise >= E_RHW, "R7 re rise to we fall", cyc - re_rise, E_RHW);
                we_fall = cyc;
            end
            if (prev_re && !re_n) begin
                check(!io_oe, "R5 oe during read", int'(io_oe), 0);
                check(cyc - we_rise >= E_WHR, "R6 we rise to re fall", cyc - we_rise, E_WHR);
                if (exact_whr)
                    check(cyc - we_rise == E_WHR, "R10 whr exact", cyc - we_rise, E_WHR);
                re_fall = cyc;
                io_in = rd_pat(rd_idx);
            end
            if (!prev_re && re_n) begin
                check(cyc - re_fall >= E_RP, "R5 re low width", cyc - re_fall, E_RP);
                re_rise = cyc;
                rd_idx++;
                io_in = 8'h00;
            end
            if (busy_dly > 0) begin
                busy_dly--;
                if (busy_dly == 0) rb_n = 1'b0;
            end else if (busy_left > 0) begin
                busy_left--;
                if (busy_left == 0) begin
                    rb_n = 1'b1;
                    rb_rise = cyc;
                end
            end
        end
        samp_cle = cle; samp_ale = ale; samp_oe = io_oe; samp_io = io_out;
        prev_we = we_n; prev_re = re_n;
    end

    // called at a falling edge; returns at the falling edge where done is seen
    task automatic issue(int op, logic [7:0] b, output logic [7:0] data, output int done_cyc);
        int t;
        cur_op = op; cur_byte = b;
        req_op = 3'(op); req_byte = b; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R9 ready drops when busy", int'(req_ready), 0);
        t = 0;
        while (!rsp_done && t < 2000) begin
            @(negedge clk);
            t++;
        end
        check(rsp_done, "R9 done pulse", int'(rsp_done), 1);
        data = rsp_data;
        done_cyc = cyc;
    endtask

    task automatic do_wr(int op, logic [7:0] b);
        logic [7:0] d; int dc;
        issue(op, b, d, dc);
    endtask

    task automatic do_read();
        logic [7:0] d, exp; int dc;
        exp = rd_pat(rd_idx);
        issue(3, 8'h00, d, dc);
        check(d == exp, "R5 read data", int'(d), int'(exp));
    endtask

    task automatic do_wait();
        logic [7:0] d; int dc;
        issue(4, 8'h00, d, dc);
        check(rb_n == 1'b1, "R8 ready at done", int'(rb_n), 1);
        check(dc - we_rise >= E_WB + E_RR, "R8 wait after we rise", dc - we_rise, E_WB + E_RR);
        if (rb_rise > we_rise)
            check(dc - rb_rise >= E_SYNC + E_RR, "R8 wait after ready", dc - rb_rise, E_SYNC + E_RR);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] cmds [8];
        void'($urandom(32'd2024));
        cmds = '{8'h00, 8'h30, 8'h80, 8'h10, 8'h60, 8'hD0, 8'h70, 8'h90};
        repeat (4) @(negedge clk);
        // R9 reset state
        check(ce_n && we_n && re_n && !io_oe && !rsp_done && req_ready,
              "R9 reset state", int'({ce_n, we_n, re_n, io_oe, rsp_done, req_ready}), 6'b111001);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // program-style sequence, exact address-to-data gap (R4, R10)
        do_wr(0, 8'h80);
        for (int i = 0; i < 5; i++) do_wr(1, 8'(i * 17 + 3));
        exact_adl = 1; do_wr(2, 8'hA5); exact_adl = 0;
        do_wr(2, 8'h5A); do_wr(2, 8'hC3);
        do_wr(0, 8'h10);
        do_wait();
        // status-style read, exact write-to-read gap (R6, R10)
        do_wr(0, 8'h70);
        exact_whr = 1; do_read(); exact_whr = 0;
        // read page sequence with busy
        do_wr(0, 8'h00);
        for (int i = 0; i < 5; i++) do_wr(1, 8'(i));
        do_wr(0, 8'h30);
        do_wait();
        for (int i = 0; i < 4; i++) do_read();
        // read then write (R7)
        do_wr(0, 8'h85);
        do_wr(1, 8'h00);
        do_wr(2, 8'hEE);
        do_read();
        do_wr(2, 8'h11);
        // wait with no busy period
        do_wait();

        // constrained random mix
        for (int k = 0; k < 150; k++) begin
            int op;
            op = int'($urandom_range(4, 0));
            case (op)
                0: do_wr(0, cmds[$urandom_range(7, 0)]);
                1: do_wr(1, 8'($urandom));
                2: do_wr(2, 8'($urandom));
                3: do_read();
                default: do_wait();
            endcase
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule